// File: doc/BRIEF.md
# Miss Status Holding Register File

This block tracks the cache misses that a non-blocking cache has sent to the next memory level and not yet had answered. Each new primary miss presents a block address, the cache set index that the refill will write, the word offset within the block, a write flag and a destination tag. Every busy entry compares its block address with the incoming miss. If one matches, the miss is merged into that entry. If none matches, the lowest-numbered free entry is claimed and one next-level request is issued. If no entry is free, the miss is stalled.

Refill responses carry only a block address, and they may arrive in any order relative to the requests. The entry whose address matches is drained one word slot per cycle. Each step drives a forward event with the stored destination tag, the word offset, the set index and the write flag. The entry becomes free at the clock edge that ends its final event. While a drain is running the block does not accept another refill, and a miss to the entry being drained is stalled.

Top module: `mshr_file`

## Requirements
- R1: After reset every entry is free. miss_stall, req_valid and fwd_valid are low, and fill_ready is high.
- R2: A miss whose block matches no busy entry, while an entry is free, raises req_valid in the same cycle. req_blk_addr equals the miss block address and req_id is the lowest-numbered free entry (entry 0 first).
- R3: When all entries are busy and a miss matches none of them, miss_stall is high in that cycle and req_valid stays low.
- R4: A miss to a busy block at a word offset that holds no tag yet is merged. It causes no stall and no request, and its tag is forwarded when the block's fill arrives.
- R5: A miss to a busy block at a word offset that already holds a tag stalls. The stored tag is kept and is the one forwarded later.
- R6: A fill accepted in cycle k produces one forward event per cycle from cycle k+1, one for each tagged word in ascending word offset. Each event carries that word's tag and the entry's set index. fwd_last is high on the final event only.
- R7: A drained entry stays busy through its final event and is free from the next cycle, where a new miss can allocate it.
- R8: Fills are matched by block address regardless of request order. A fill whose address matches no busy entry produces no forward event.
- R9: fill_ready is low while forward events are being produced. A fill presented then is ignored and produces no forward event later.
- R10: A miss to the block being drained, or to the block whose fill is accepted in the same cycle, stalls.
- R11: A new allocation and a fill acceptance in the same cycle both take effect.
- R12: A word recorded by a write miss is forwarded with fwd_is_write high. A word recorded by a read miss is forwarded with it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A primary miss is presented |
| miss_blk_addr | input | ADDR_W | Block address of the miss |
| miss_index | input | IDX_W | Cache set index the refill will write |
| miss_word | input | WOFF_W | Word offset within the block |
| miss_is_write | input | 1 | Miss comes from a store |
| miss_dest | input | TAG_W | Destination tag for forwarding |
| miss_stall | output | 1 | Miss not accepted this cycle |
| req_valid | output | 1 | Issue one next-level block request |
| req_blk_addr | output | ADDR_W | Block address to request |
| req_id | output | ID_W | Entry allocated for the request |
| fill_valid | input | 1 | A refill block has arrived |
| fill_blk_addr | input | ADDR_W | Block address of the refill |
| fill_ready | output | 1 | A refill can be accepted this cycle |
| fwd_valid | output | 1 | Forward event valid |
| fwd_dest | output | TAG_W | Destination tag of the forwarded word |
| fwd_word | output | WOFF_W | Word offset being forwarded |
| fwd_index | output | IDX_W | Set index of the refilled block |
| fwd_is_write | output | 1 | Forwarded word belongs to a pending store |
| fwd_last | output | 1 | Final forward event of this block |

## Verification
A corrupted busy bit appears at the ports in the same cycle that a miss reaches that entry. A lost bit makes a duplicate request appear on req_valid. A stuck bit shows up as a stall even though an entry is free, or as the wrong req_id. A damaged word mask or tag shows up in the first forward event after the fill, as a missing or extra event, an event out of offset order, or a wrong tag or write flag. Missing drain bookkeeping appears one cycle after the last event, when fill_ready does not return or the freed entry cannot be allocated again.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

    // Drain sequencer states
    typedef enum logic {
        DRN_IDLE = 1'b0,
        DRN_RUN  = 1'b1
    } drain_state_e;

    // Index of the lowest set bit of v (0 when v is zero); widths up to 32
    function automatic logic [4:0] first_one(input logic [31:0] v);
        logic [4:0] r;
        r = '0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = 5'(i);
        end
        return r;
    endfunction

    // True when at most one bit of v is set
    function automatic logic single_bit(input logic [31:0] v);
        return (v & (v - 32'd1)) == 32'd0;
    endfunction

endpackage

// File: rtl/mshr_pick.sv
module mshr_pick #(
    parameter int W    = 4,
    parameter int ID_W = 2
) (
    input  logic [W-1:0]    vec,
    output logic            any,
    output logic [ID_W-1:0] id
);
    import mshr_pkg::*;

    assign any = |vec;
    assign id  = ID_W'(first_one(32'(vec)));
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry #(
    parameter int ADDR_W = 26,
    parameter int IDX_W  = 7,
    parameter int TAG_W  = 6,
    parameter int WORDS  = 4,
    parameter int WOFF_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_en,
    input  logic                   merge_en,
    input  logic                   free_en,
    input  logic [ADDR_W-1:0]      in_addr,
    input  logic [IDX_W-1:0]       in_index,
    input  logic [WOFF_W-1:0]      in_word,
    input  logic                   in_write,
    input  logic [TAG_W-1:0]       in_dest,
    input  logic [ADDR_W-1:0]      fill_addr,
    output logic                   busy,
    output logic                   miss_hit,
    output logic                   fill_hit,
    output logic [IDX_W-1:0]       index,
    output logic [WORDS-1:0]       wmask,
    output logic [WORDS-1:0]       wrmask,
    output logic [WORDS*TAG_W-1:0] dests
);
    logic [ADDR_W-1:0] addr_q;
    logic [WORDS-1:0]  word_oh;

    assign word_oh  = WORDS'(1) << in_word;
    assign miss_hit = busy && (addr_q == in_addr);
    assign fill_hit = busy && (addr_q == fill_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            wmask  <= '0;
            wrmask <= '0;
            addr_q <= '0;
            index  <= '0;
        end else if (free_en) begin
            busy   <= 1'b0;
            wmask  <= '0;
            wrmask <= '0;
        end else if (alloc_en) begin
            busy   <= 1'b1;
            addr_q <= in_addr;
            index  <= in_index;
            wmask  <= word_oh;
            wrmask <= in_write ? word_oh : '0;
        end else if (merge_en) begin
            wmask  <= wmask | word_oh;
            wrmask <= wrmask | (in_write ? word_oh : '0);
        end
    end

    // Tag storage: data only, no reset needed
    always_ff @(posedge clk) begin
        if (!rst && !free_en && (alloc_en || merge_en)) begin
            dests[in_word*TAG_W +: TAG_W] <= in_dest;
        end
    end
endmodule

// File: rtl/mshr_drain.sv
module mshr_drain #(
    parameter int WORDS  = 4,
    parameter int WOFF_W = 2,
    parameter int ID_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ID_W-1:0]   take_id,
    input  logic [WORDS-1:0]  take_mask,
    output logic              active,
    output logic [ID_W-1:0]   cur_id,
    output logic [WOFF_W-1:0] cur_word,
    output logic              last
);
    import mshr_pkg::*;

    drain_state_e     state;
    logic [WORDS-1:0] mask;

    assign active   = (state == DRN_RUN);
    assign cur_word = WOFF_W'(first_one(32'(mask)));
    assign last     = single_bit(32'(mask));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= DRN_IDLE;
            mask   <= '0;
            cur_id <= '0;
        end else if (state == DRN_RUN) begin
            mask <= mask & ~(WORDS'(1) << cur_word);
            if (last) state <= DRN_IDLE;
        end else if (take) begin
            state  <= DRN_RUN;
            mask   <= take_mask;
            cur_id <= take_id;
        end
    end
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
    parameter int N      = 4,
    parameter int ADDR_W = 26,
    parameter int IDX_W  = 7,
    parameter int TAG_W  = 6,
    parameter int WORDS  = 4,
    localparam int ID_W   = (N > 1) ? $clog2(N) : 1,
    localparam int WOFF_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_blk_addr,
    input  logic [IDX_W-1:0]  miss_index,
    input  logic [WOFF_W-1:0] miss_word,
    input  logic              miss_is_write,
    input  logic [TAG_W-1:0]  miss_dest,
    output logic              miss_stall,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_blk_addr,
    output logic [ID_W-1:0]   req_id,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_blk_addr,
    output logic              fill_ready,
    output logic              fwd_valid,
    output logic [TAG_W-1:0]  fwd_dest,
    output logic [WOFF_W-1:0] fwd_word,
    output logic [IDX_W-1:0]  fwd_index,
    output logic              fwd_is_write,
    output logic              fwd_last
);
    logic [N-1:0]             e_valid, e_mhit, e_fhit;
    logic [N-1:0]             alloc_en, merge_en, free_en;
    logic [IDX_W-1:0]         e_index  [N];
    logic [WORDS-1:0]         e_wmask  [N];
    logic [WORDS-1:0]         e_wrmask [N];
    logic [WORDS*TAG_W-1:0]   e_dest   [N];

    logic              free_any, hit_any, fhit_any;
    logic [ID_W-1:0]   free_id, hit_id, fhit_id;
    logic              drn_active, drn_last;
    logic [ID_W-1:0]   drn_id;
    logic [WOFF_W-1:0] drn_word;
    logic              fill_take, hit_busy, word_taken, conflict;
    logic              do_alloc, do_merge;

    mshr_pick #(.W(N), .ID_W(ID_W)) u_free (.vec(~e_valid), .any(free_any), .id(free_id));
    mshr_pick #(.W(N), .ID_W(ID_W)) u_hit  (.vec(e_mhit),   .any(hit_any),  .id(hit_id));
    mshr_pick #(.W(N), .ID_W(ID_W)) u_fhit (.vec(e_fhit),   .any(fhit_any), .id(fhit_id));

    // Fill acceptance and conflict detection
    assign fill_ready = !drn_active;
    assign fill_take  = fill_valid && !drn_active && fhit_any;
    assign hit_busy   = (drn_active && (drn_id == hit_id)) || (fill_take && (fhit_id == hit_id));
    assign word_taken = e_wmask[hit_id][miss_word];
    assign conflict   = hit_any && (word_taken || hit_busy);

    assign do_alloc   = miss_valid && !hit_any && free_any;
    assign do_merge   = miss_valid && hit_any && !conflict;
    assign miss_stall = miss_valid && (hit_any ? conflict : !free_any);

    assign req_valid    = do_alloc;
    assign req_blk_addr = miss_blk_addr;
    assign req_id       = free_id;

    for (genvar i = 0; i < N; i++) begin : g_ent
        assign alloc_en[i] = do_alloc && (free_id == ID_W'(i));
        assign merge_en[i] = do_merge && (hit_id == ID_W'(i));
        assign free_en[i]  = drn_active && drn_last && (drn_id == ID_W'(i));

        mshr_entry #(
            .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
            .WORDS(WORDS), .WOFF_W(WOFF_W)
        ) u_ent (
            .clk      (clk),
            .rst      (rst),
            .alloc_en (alloc_en[i]),
            .merge_en (merge_en[i]),
            .free_en  (free_en[i]),
            .in_addr  (miss_blk_addr),
            .in_index (miss_index),
            .in_word  (miss_word),
            .in_write (miss_is_write),
            .in_dest  (miss_dest),
            .fill_addr(fill_blk_addr),
            .busy     (e_valid[i]),
            .miss_hit (e_mhit[i]),
            .fill_hit (e_fhit[i]),
            .index    (e_index[i]),
            .wmask    (e_wmask[i]),
            .wrmask   (e_wrmask[i]),
            .dests    (e_dest[i])
        );
    end

    mshr_drain #(.WORDS(WORDS), .WOFF_W(WOFF_W), .ID_W(ID_W)) u_drain (
        .clk      (clk),
        .rst      (rst),
        .take     (fill_take),
        .take_id  (fhit_id),
        .take_mask(e_wmask[fhit_id]),
        .active   (drn_active),
        .cur_id   (drn_id),
        .cur_word (drn_word),
        .last     (drn_last)
    );

    assign fwd_valid    = drn_active;
    assign fwd_word     = drn_word;
    assign fwd_dest     = e_dest[drn_id][drn_word*TAG_W +: TAG_W];
    assign fwd_index    = e_index[drn_id];
    assign fwd_is_write = e_wrmask[drn_id][drn_word];
    assign fwd_last     = drn_active && drn_last;
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
    parameter int N      = 4,
    parameter int IDX_W  = 7,
    parameter int WOFF_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              miss_valid,
    input logic              miss_stall,
    input logic              req_valid,
    input logic              fill_ready,
    input logic              fwd_valid,
    input logic              fwd_last,
    input logic [WOFF_W-1:0] fwd_word,
    input logic [IDX_W-1:0]  fwd_index,
    input logic [N-1:0]      e_valid
);
    // R2: a request only comes from an accepted miss
    a_r2_req_from_miss: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (miss_valid && !miss_stall));

    // R3: a request is never issued with every entry busy
    a_r3_req_needs_room: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ($countones(e_valid) < N));

    // R9: no fill is accepted while forwarding
    a_r9_no_fill_in_drain: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> !fill_ready);

    // R6: events of one block rise in word offset with a stable index
    a_r6_ascending_words: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && !fwd_last) |=> (fwd_valid && (fwd_word > $past(fwd_word))
                                      && (fwd_index == $past(fwd_index))));

    // R7: after the final event the fill path reopens and no entry is gained
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && fwd_last) |=> (fill_ready
            && ($countones(e_valid) <= $past($countones(e_valid)))));
endmodule

bind mshr_file mshr_file_chk #(.N(N), .IDX_W(IDX_W), .WOFF_W(WOFF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .miss_valid(miss_valid),
    .miss_stall(miss_stall),
    .req_valid (req_valid),
    .fill_ready(fill_ready),
    .fwd_valid (fwd_valid),
    .fwd_last  (fwd_last),
    .fwd_word  (fwd_word),
    .fwd_index (fwd_index),
    .e_valid   (e_valid)
);

// File: tb/mshr_file_test.sv
module mshr_file_test;
    localparam int N = 4, ADDR_W = 26, IDX_W = 7, TAG_W = 6, WORDS = 4;
    localparam int ID_W = 2, WOFF_W = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic miss_valid = 0, miss_is_write = 0, fill_valid = 0;
    logic [ADDR_W-1:0] miss_blk_addr = '0, fill_blk_addr = '0;
    logic [IDX_W-1:0] miss_index = '0;
    logic [WOFF_W-1:0] miss_word = '0;
    logic [TAG_W-1:0] miss_dest = '0;
    logic miss_stall, req_valid, fill_ready, fwd_valid, fwd_is_write, fwd_last;
    logic [ADDR_W-1:0] req_blk_addr;
    logic [ID_W-1:0] req_id;
    logic [TAG_W-1:0] fwd_dest;
    logic [WOFF_W-1:0] fwd_word;
    logic [IDX_W-1:0] fwd_index;

    int total = 0, bad = 0;

    always #2 clk = ~clk;

    mshr_file #(.N(N), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .WORDS(WORDS)) uut (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_blk_addr(miss_blk_addr),
        .miss_index(miss_index), .miss_word(miss_word), .miss_is_write(miss_is_write),
        .miss_dest(miss_dest), .miss_stall(miss_stall), .req_valid(req_valid),
        .req_blk_addr(req_blk_addr), .req_id(req_id), .fill_valid(fill_valid),
        .fill_blk_addr(fill_blk_addr), .fill_ready(fill_ready), .fwd_valid(fwd_valid),
        .fwd_dest(fwd_dest), .fwd_word(fwd_word), .fwd_index(fwd_index),
        .fwd_is_write(fwd_is_write), .fwd_last(fwd_last)
    );

    // {addr, index, word, write, dest, exp_stall, exp_req, exp_id}
    localparam int VW = 46;
    localparam logic [VW-1:0] VEC [8] = '{
        {26'h100, 7'd1, 2'd2, 1'b0, 6'd5,  1'b0, 1'b1, 2'd0}, // R2 first alloc
        {26'h100, 7'd1, 2'd0, 1'b0, 6'd6,  1'b0, 1'b0, 2'd0}, // R4 merge
        {26'h100, 7'd1, 2'd2, 1'b0, 6'd9,  1'b1, 1'b0, 2'd0}, // R5 tagged word
        {26'h200, 7'd2, 2'd1, 1'b1, 6'd7,  1'b0, 1'b1, 2'd1}, // R2 write miss
        {26'h300, 7'd3, 2'd3, 1'b0, 6'd8,  1'b0, 1'b1, 2'd2}, // R2
        {26'h400, 7'd4, 2'd0, 1'b0, 6'd10, 1'b0, 1'b1, 2'd3}, // R2 last free
        {26'h500, 7'd5, 2'd0, 1'b0, 6'd1,  1'b1, 1'b0, 2'd0}, // R3 full
        {26'h400, 7'd4, 2'd3, 1'b1, 6'd11, 1'b0, 1'b0, 2'd0}  // R4 merge write
    };

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic set_miss(input logic v, input logic [ADDR_W-1:0] a, input logic [IDX_W-1:0] ix,
                            input logic [WOFF_W-1:0] w, input logic wr, input logic [TAG_W-1:0] d);
        miss_valid = v; miss_blk_addr = a; miss_index = ix;
        miss_word = w; miss_is_write = wr; miss_dest = d;
    endtask

    task automatic set_fill(input logic v, input logic [ADDR_W-1:0] a);
        fill_valid = v; fill_blk_addr = a;
    endtask

    task automatic chk_fwd(input string r, input logic [WOFF_W-1:0] w, input logic [TAG_W-1:0] d,
                           input logic [IDX_W-1:0] ix, input logic wr, input logic lst);
        chk({r, " fwd_valid"}, 32'(fwd_valid), 32'd1);
        chk({r, " fwd_word"}, 32'(fwd_word), 32'(w));
        chk({r, " fwd_dest"}, 32'(fwd_dest), 32'(d));
        chk({r, " fwd_index"}, 32'(fwd_index), 32'(ix));
        chk({r, " fwd_is_write"}, 32'(fwd_is_write), 32'(wr));
        chk({r, " fwd_last"}, 32'(fwd_last), 32'(lst));
    endtask

    // each step: drive after the falling edge, sample 1 ns later
    task automatic nxt;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        nxt(); rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 stall", 32'(miss_stall), 0);
        chk("R1 req", 32'(req_valid), 0);
        chk("R1 fwd", 32'(fwd_valid), 0);
        chk("R1 fill_ready", 32'(fill_ready), 1);

        for (int i = 0; i < 8; i++) begin
            nxt();
            set_miss(1'b1, VEC[i][45:20], VEC[i][19:13], VEC[i][12:11], VEC[i][10], VEC[i][9:4]);
            #1;
            chk($sformatf("R2/R3/R4/R5 vec%0d stall", i), 32'(miss_stall), 32'(VEC[i][3]));
            chk($sformatf("R2/R3/R4 vec%0d req", i), 32'(req_valid), 32'(VEC[i][2]));
            if (VEC[i][2]) begin
                chk($sformatf("R2 vec%0d req_id", i), 32'(req_id), 32'(VEC[i][1:0]));
                chk($sformatf("R2 vec%0d req_addr", i), 32'(req_blk_addr), 32'(VEC[i][45:20]));
            end
        end

        // R8 out-of-order fill of the third request
        nxt(); set_miss(0, '0, '0, '0, 0, '0); set_fill(1, 26'h300);
        #1; chk("R8 fill_ready", 32'(fill_ready), 1); chk("R8 no fwd yet", 32'(fwd_valid), 0);
        nxt(); set_fill(0, '0); set_miss(1, 26'h500, 7'd5, 2'd0, 0, 6'd1);
        #1; chk_fwd("R6 R8", 2'd3, 6'd8, 7'd3, 0, 1);
        chk("R7 still busy on last", 32'(miss_stall), 1);
        // R7 R11: alloc of freed entry and fill acceptance together
        nxt(); set_miss(1, 26'h600, 7'd6, 2'd1, 0, 6'd12); set_fill(1, 26'h100);
        #1; chk("R7 req", 32'(req_valid), 1); chk("R7 R11 req_id", 32'(req_id), 2);
        chk("R11 fill_ready", 32'(fill_ready), 1); chk("R11 stall", 32'(miss_stall), 0);
        nxt(); set_miss(1, 26'h100, 7'd1, 2'd1, 0, 6'd3); set_fill(1, 26'h200);
        #1; chk_fwd("R4 R6 R11", 2'd0, 6'd6, 7'd1, 0, 0);
        chk("R9 ready low", 32'(fill_ready), 0); chk("R10 drain stall", 32'(miss_stall), 1);
        nxt(); set_miss(0, '0, '0, '0, 0, '0); set_fill(0, '0);
        #1; chk_fwd("R5 R6", 2'd2, 6'd5, 7'd1, 0, 1);
        nxt(); set_fill(1, 26'h777);
        #1; chk("R9 ignored fill", 32'(fwd_valid), 0); chk("R9 ready back", 32'(fill_ready), 1);
        nxt(); set_fill(0, '0);
        #1; chk("R8 unmatched fill", 32'(fwd_valid), 0);
        nxt(); set_fill(1, 26'h400);
        nxt(); set_fill(0, '0);
        #1; chk_fwd("R12 read word", 2'd0, 6'd10, 7'd4, 0, 0);
        nxt(); #1; chk_fwd("R12 write word", 2'd3, 6'd11, 7'd4, 1, 1);
        nxt(); set_fill(1, 26'h200);
        nxt(); set_fill(0, '0);
        #1; chk_fwd("R8 R12 refill", 2'd1, 6'd7, 7'd2, 1, 1);
        nxt(); set_fill(1, 26'h600);
        nxt(); set_fill(0, '0);
        #1; chk_fwd("R6 R11 new entry", 2'd1, 6'd12, 7'd6, 0, 1);
        // R2 all free again: lowest entry chosen
        nxt(); set_miss(1, 26'h800, 7'd8, 2'd0, 0, 6'd20);
        #1; chk("R2 realloc req", 32'(req_valid), 1); chk("R2 realloc id", 32'(req_id), 0);
        // R10 merge in the fill-acceptance cycle stalls
        nxt(); set_miss(1, 26'h800, 7'd8, 2'd2, 0, 6'd21); set_fill(1, 26'h800);
        #1; chk("R10 same-cycle stall", 32'(miss_stall), 1); chk("R10 no req", 32'(req_valid), 0);
        nxt(); set_miss(0, '0, '0, '0, 0, '0); set_fill(0, '0);
        #1; chk_fwd("R10 single word", 2'd0, 6'd20, 7'd8, 0, 1);
        nxt(); #1; chk("R7 idle after", 32'(fwd_valid), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule